// File: doc/BRIEF.md
# DRAM Page-Policy Command Sequencer

This block turns single memory requests into DRAM command sequences. A request names a bank, a row and a direction (read or write). The block keeps an open-row table with one entry per bank. Each entry holds an open flag and the row held in that bank. On acceptance, the request is checked against its bank's entry and falls into one of three classes:

- **Closed bank:** the sequence is activate, then the column command.
- **Row conflict:** the sequence is precharge, activate, then the column command.
- **Row hit:** the sequence is the column command alone.

Commands leave on a valid/ready port, one per accepted handshake. The table is updated as precharge and activate commands are accepted. The block takes only one request at a time, so the next request is always classified against an up-to-date table. A controller places this block between its request queue and the timing checker that faces the DRAM devices.

Top module: `dram_page_seq`

## Requirements
- R1: After reset every bank is marked closed, `req_ready_o` is 1, `cmd_valid_o` is 0 and `done_o` is 0.
- R2: A request to a bank with no open row produces activate (code 2) followed by the column command.
- R3: A request to a bank whose open row differs from the requested row produces precharge (code 0), then activate (code 2), then the column command.
- R4: A request whose row is already open in its bank produces only the column command.
- R5: A read ends in code 3 and a write ends in code 4. The 4-bit command field defines precharge-all=1, read-auto-precharge=5, write-auto-precharge=6, refresh=7 and refresh-trigger=8, but the block never emits these codes.
- R6: Each bank's entry is tracked separately. Opening a row in one bank has no effect on how a request to another bank is classified.
- R7: An accepted activate marks its bank open with the request's row. An accepted precharge marks its bank closed. Both updates are in effect before the next request is classified.
- R8: `req_ready_o` is 1 only when no sequence is in progress. In the cycle after a request is accepted, it is 0.
- R9: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, the command code, bank and row outputs hold their values, and `cmd_valid_o` stays 1.
- R10: `done_o` is 1 for exactly the cycles in which the final column command of a sequence is accepted.
- R11: Every command of a sequence carries the bank and row of the request that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request can be accepted |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_write_i | input | 1 | 1 = write, 0 = read |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Command taken |
| cmd_code_o | output | 4 | Command code |
| cmd_bank_o | output | BANK_W | Command bank |
| cmd_row_o | output | ROW_W | Command row |
| done_o | output | 1 | Final command of a sequence accepted |

## Verification
The bench uses the default build of 8 banks and 14-bit rows. With these values the highest bank index, 7, and the all-ones row 16383 can be addressed directly, so both are exercised. Rows are drawn mostly from a set of four values. This makes hits and conflicts frequent in every bank, and it interleaves banks so that the per-bank independence of R6 is tested. Back-pressure on the command port varies from cycle to cycle. As a result, stalls fall on every step of all three sequence lengths.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [3:0] {
    CMD_PRE  = 4'd0,
    CMD_PREA = 4'd1,
    CMD_ACT  = 4'd2,
    CMD_RD   = 4'd3,
    CMD_WR   = 4'd4,
    CMD_RDA  = 4'd5,
    CMD_WRA  = 4'd6,
    CMD_REF  = 4'd7,
    CMD_REFT = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    PG_CLOSED   = 2'd0,
    PG_CONFLICT = 2'd1,
    PG_HIT      = 2'd2
  } page_class_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_ACT  = 2'd2,
    ST_RW   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/open_row_table.sv
module open_row_table #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_en_i,
  input  logic              pre_en_i,
  input  logic [BANK_W-1:0] upd_bank_i,
  input  logic [ROW_W-1:0]  upd_row_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  output logic              rd_open_o,
  output logic [ROW_W-1:0]  rd_row_o
);

  logic             open_q [NUM_BANKS];
  logic [ROW_W-1:0] row_q  [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_bank;
    assign hit_bank = (upd_bank_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (act_en_i && hit_bank) begin
        open_q[b] <= 1'b1;
        row_q[b]  <= upd_row_i;
      end else if (pre_en_i && hit_bank) begin
        open_q[b] <= 1'b0;
      end
    end
  end

  assign rd_open_o = open_q[rd_bank_i];
  assign rd_row_o  = row_q[rd_bank_i];

  // R7: table reflects accepted activate/precharge on the next cycle
  p_act_opens_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_en_i |=> (open_q[$past(upd_bank_i)] && row_q[$past(upd_bank_i)] == $past(upd_row_i)));
  p_pre_closes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_en_i |=> !open_q[$past(upd_bank_i)]);
  p_upd_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_en_i && pre_en_i));

endmodule

// File: rtl/page_classifier.sv
module page_classifier
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             bank_open_i,
  input  logic [ROW_W-1:0] open_row_i,
  input  logic [ROW_W-1:0] req_row_i,
  output page_class_e      pg_class_o
);

  always_comb begin
    if (!bank_open_i)                pg_class_o = PG_CLOSED;
    else if (open_row_i != req_row_i) pg_class_o = PG_CONFLICT;
    else                             pg_class_o = PG_HIT;
  end

endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 14,
  parameter int BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic              req_write_i,
  input  page_class_e       pg_class_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [3:0]        cmd_code_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic              done_o,
  output logic              act_en_o,
  output logic              pre_en_o
);

  seq_state_e        state_q, state_d;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic              write_q;
  logic              req_fire, cmd_fire;

  assign req_ready_o = (state_q == ST_IDLE);
  assign req_fire    = req_valid_i && req_ready_o;
  assign cmd_valid_o = (state_q != ST_IDLE);
  assign cmd_fire    = cmd_valid_o && cmd_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_fire) begin
        unique case (pg_class_i)
          PG_CLOSED:   state_d = ST_ACT;
          PG_CONFLICT: state_d = ST_PRE;
          default:     state_d = ST_RW;
        endcase
      end
      ST_PRE:  if (cmd_ready_i) state_d = ST_ACT;
      ST_ACT:  if (cmd_ready_i) state_d = ST_RW;
      default: if (cmd_ready_i) state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bank_q  <= '0;
      row_q   <= '0;
      write_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (req_fire) begin
        bank_q  <= req_bank_i;
        row_q   <= req_row_i;
        write_q <= req_write_i;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PRE:  cmd_code_o = CMD_PRE;
      ST_ACT:  cmd_code_o = CMD_ACT;
      ST_RW:   cmd_code_o = write_q ? CMD_WR : CMD_RD;
      default: cmd_code_o = CMD_PRE;
    endcase
  end

  assign cmd_bank_o = bank_q;
  assign cmd_row_o  = row_q;
  assign done_o     = cmd_fire && (state_q == ST_RW);
  assign act_en_o   = cmd_fire && (state_q == ST_ACT);
  assign pre_en_o   = cmd_fire && (state_q == ST_PRE);

  p_ready_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_fire |=> !req_ready_o);
  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_code_o) && $stable(cmd_bank_o) && $stable(cmd_row_o)));
  p_pre_then_act_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_fire && cmd_code_o == CMD_PRE) |=> (cmd_valid_o && cmd_code_o == CMD_ACT));
  p_act_then_col_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_fire && cmd_code_o == CMD_ACT) |=>
      (cmd_valid_o && (cmd_code_o == CMD_RD || cmd_code_o == CMD_WR)));
  p_hit_direct_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_fire && pg_class_i == PG_HIT) |=>
      (cmd_valid_o && (cmd_code_o == CMD_RD || cmd_code_o == CMD_WR)));
  p_no_auto_pre_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_code_o inside {CMD_PRE, CMD_ACT, CMD_RD, CMD_WR}));
  p_done_on_col_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cmd_valid_o && cmd_ready_i && (cmd_code_o == CMD_RD || cmd_code_o == CMD_WR)));

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic              req_write_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [3:0]        cmd_code_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic              done_o
);

  logic             tbl_open;
  logic [ROW_W-1:0] tbl_row;
  logic             act_en, pre_en;
  page_class_e      pg_class;

  // Table is read with the incoming bank; updates use the latched command bank.
  open_row_table #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .BANK_W    (BANK_W)
  ) i_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_en_i   (act_en),
    .pre_en_i   (pre_en),
    .upd_bank_i (cmd_bank_o),
    .upd_row_i  (cmd_row_o),
    .rd_bank_i  (req_bank_i),
    .rd_open_o  (tbl_open),
    .rd_row_o   (tbl_row)
  );

  page_classifier #(.ROW_W(ROW_W)) i_class (
    .bank_open_i (tbl_open),
    .open_row_i  (tbl_row),
    .req_row_i   (req_row_i),
    .pg_class_o  (pg_class)
  );

  cmd_sequencer #(.ROW_W(ROW_W), .BANK_W(BANK_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_bank_i  (req_bank_i),
    .req_row_i   (req_row_i),
    .req_write_i (req_write_i),
    .pg_class_i  (pg_class),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_code_o  (cmd_code_o),
    .cmd_bank_o  (cmd_bank_o),
    .cmd_row_o   (cmd_row_o),
    .done_o      (done_o),
    .act_en_o    (act_en),
    .pre_en_o    (pre_en)
  );

  // R11: command fields hold the accepted request for the whole sequence
  p_fields_fixed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !done_o) |=> ($stable(cmd_bank_o) && $stable(cmd_row_o)));

endmodule

// File: tb/test_dram_page_seq.sv
module test_dram_page_seq;

  localparam int NB     = 8;
  localparam int RW     = 14;
  localparam int BW     = 3;
  localparam int WDOG   = 100000;

  typedef struct packed {
    logic [3:0]    code;
    logic [BW-1:0] bank;
    logic [RW-1:0] row;
    logic          last;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [BW-1:0] req_bank_i = '0;
  logic [RW-1:0] req_row_i = '0;
  logic          req_write_i = 1'b0;
  logic          cmd_valid_o;
  logic          cmd_ready_i = 1'b0;
  logic [3:0]    cmd_code_o;
  logic [BW-1:0] cmd_bank_o;
  logic [RW-1:0] cmd_row_o;
  logic          done_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  exp_t  exp_q[$];
  string tag_q[$];

  logic          mdl_open [NB];
  logic [RW-1:0] mdl_row  [NB];

  always #5 clk = ~clk;

  dram_page_seq #(.NUM_BANKS(NB), .ROW_W(RW)) i_dram_page_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_bank_i  (req_bank_i),
    .req_row_i   (req_row_i),
    .req_write_i (req_write_i),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_code_o  (cmd_code_o),
    .cmd_bank_o  (cmd_bank_o),
    .cmd_row_o   (cmd_row_o),
    .done_o      (done_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  function automatic void push(input logic [3:0] c, input logic [BW-1:0] b,
                               input logic [RW-1:0] r, input logic l, input string t);
    exp_t e;
    e.code = c; e.bank = b; e.row = r; e.last = l;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endfunction

  // Driver: predicts the sequence from the model table, then offers the request.
  task automatic send(input int b, input int r, input bit wr);
    logic [3:0] col;
    string      ctag;
    col  = wr ? 4'd4 : 4'd3;
    ctag = wr ? "R5-wr" : "R5-rd";
    if (!mdl_open[b]) begin                 // R2 closed bank
      push(4'd2, BW'(b), RW'(r), 1'b0, "R2");
      push(col,  BW'(b), RW'(r), 1'b1, ctag);
    end else if (mdl_row[b] != RW'(r)) begin // R3 conflict
      push(4'd0, BW'(b), RW'(r), 1'b0, "R3");
      push(4'd2, BW'(b), RW'(r), 1'b0, "R3");
      push(col,  BW'(b), RW'(r), 1'b1, ctag);
    end else begin                          // R4 hit
      push(col,  BW'(b), RW'(r), 1'b1, "R4");
    end
    mdl_open[b] = 1'b1;                     // R7 model update
    mdl_row[b]  = RW'(r);
    @(negedge clk);
    req_valid_i = 1'b1;
    req_bank_i  = BW'(b);
    req_row_i   = RW'(r);
    req_write_i = wr;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    chk(req_ready_o == 1'b0, "R8", "ready after accept", int'(req_ready_o), 0);
    req_valid_i = 1'b0;
  endtask

  // Monitor / scoreboard
  logic [7:0]    lfsr = 8'hA5;
  logic          prev_stall = 1'b0;
  logic [3:0]    prev_code;
  logic [BW-1:0] prev_bank;
  logic [RW-1:0] prev_row;

  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cmd_ready_i = lfsr[0] | lfsr[2];
      #1;
      if (prev_stall) begin
        chk(cmd_valid_o && cmd_code_o == prev_code && cmd_bank_o == prev_bank &&
            cmd_row_o == prev_row, "R9", "held code", int'(cmd_code_o), int'(prev_code));
      end
      if (cmd_valid_o) begin
        chk(cmd_code_o inside {4'd0, 4'd2, 4'd3, 4'd4}, "R5", "legal code",
            int'(cmd_code_o), 3);
      end
      if (cmd_valid_o && cmd_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", "unexpected command", int'(cmd_code_o), -1);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cmd_code_o == e.code, t, "code", int'(cmd_code_o), int'(e.code));
          chk(cmd_bank_o == e.bank, "R11", "bank", int'(cmd_bank_o), int'(e.bank));
          chk(cmd_row_o == e.row, "R11", "row", int'(cmd_row_o), int'(e.row));
          chk(done_o == e.last, "R10", "done on fire", int'(done_o), int'(e.last));
        end
      end else begin
        chk(done_o == 1'b0, "R10", "done idle", int'(done_o), 0);
      end
      prev_stall = cmd_valid_o && !cmd_ready_i;
      prev_code  = cmd_code_o;
      prev_bank  = cmd_bank_o;
      prev_row   = cmd_row_o;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      chk(1'b0, "R8", "watchdog expired", cycles, WDOG);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      mdl_open[i] = 1'b0;
      mdl_row[i]  = '0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready_o == 1'b1, "R1", "ready in reset", int'(req_ready_o), 1);
    chk(cmd_valid_o == 1'b0, "R1", "valid in reset", int'(cmd_valid_o), 0);
    chk(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1'b1 && cmd_valid_o == 1'b0, "R1", "idle after reset",
        int'(cmd_valid_o), 0);

    // Directed: closed, hit, conflict, independent bank (R6), boundaries
    send(0, 3, 1'b0);              // R2
    send(0, 3, 1'b1);              // R4
    send(0, 4, 1'b0);              // R3
    send(1, 4, 1'b1);              // R6: bank 1 still closed
    send(1, 4, 1'b0);              // R4
    send(0, 4, 1'b1);              // R7: bank 0 holds row 4
    send(NB - 1, (1 << RW) - 1, 1'b1); // top bank, all-ones row
    send(NB - 1, (1 << RW) - 1, 1'b0);
    send(NB - 1, 0, 1'b0);         // R3 from all-ones row

    // Mixed stream
    for (int n = 0; n < 300; n++) begin
      int b, r;
      b = $urandom_range(NB - 1, 0);
      r = ($urandom_range(9, 0) == 0) ? ((1 << RW) - 1) : $urandom_range(3, 0);
      send(b, r, 1'($urandom_range(1, 0)));
    end

    while (exp_q.size() != 0 || !req_ready_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "queue drained", exp_q.size(), 0);
    summary();
  end

endmodule